// File: doc/BRIEF.md
# NOR Flash Command Sequencer for a Byte-Addressed Host

This block sits between a processor bus that addresses bytes and a 16-bit NOR flash whose word address pin 0 is wired to host address bit 1. Host address bit 0 never reaches the flash. The block only uses it to pick a byte lane. A single start strobe with an operation code runs one complete bus sequence on the flash pins:

- manufacturer/device identifier read
- query-table read
- word program
- reset to array mode
- single byte read

Every command address is the flash word address shifted left by one. For example, the unlock cycles go to host addresses 0xAAA and 0x554.

Each flash bus cycle lasts a programmable number of clocks, with a minimum of three. Address and write data stay steady for the whole cycle. Write enable is low only in the middle of the cycle, and output enable covers a whole read cycle. Each value read back is presented on a return port with a one-clock valid strobe and its ordinal within the sequence. A one-clock done pulse marks the end of the sequence.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: Out of reset and while idle, `ce_n`, `oe_n` and `we_n` are high, `dq_oe` is low, and `done` and `rvalid` are low.
- R2: A bus cycle lasts max(`cyc_len`,3) clocks, sampled at start. `bus_addr` and `dq_out` hold steady through it. In a write cycle `we_n` is high in the first and last clock and low in between (len-2 clocks). In a read cycle `oe_n` is low for all len clocks. `we_n` and `oe_n` are never low together.
- R3: `op`=0 (identifier) writes 0xAA to 0xAAA, 0x55 to 0x554 and 0x90 to 0xAAA. It then reads host addresses 0 and 2, and finally writes 0xF0 to address 0.
- R4: `op`=1 (query) writes 0x98 to 0xAA and reads host addresses 0x20, 0x22, 0x24 and 0x4E in that order. It then writes 0xF0 to address 0.
- R5: `op`=2 (program) issues the two unlock writes of R3 and then writes 0xA0 to 0xAAA. It then writes `wr_data` to `tgt_addr` with bit 0 forced to 0.
- R6: `op`=3 (reset) issues one write of 0xF0 to address 0.
- R7: `op`=4 (byte read) reads the word at `tgt_addr` with bit 0 cleared. `rdata[7:0]` is the low byte of that word when `tgt_addr[0]`=0 and the high byte when it is 1. `rdata[15:8]` is 0.
- R8: One clock after each read cycle ends, `rvalid` pulses for one clock. `rdata` then carries the captured word, full 16 bits for operations 0 and 1, and `rindex` carries the read's ordinal from 0.
- R9: During a cycle `bus_addr[0]` is 0, and `tgt_addr` bits 26:1 reach `bus_addr` unmasked, even above the 2 MB that the flash decodes.
- R10: `start` is ignored while a sequence runs, and operation codes 5 to 7 start nothing.
- R11: `done` is a one-clock pulse in the clock after the last cycle ends. The start edge and the edge that raises `done` are steps×len clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (sampled when idle) |
| op | input | 3 | Operation code: 0 id, 1 query, 2 program, 3 reset, 4 byte read |
| tgt_addr | input | 27 | Host byte address for program and byte read |
| wr_data | input | 16 | Word to program |
| cyc_len | input | 8 | Clocks per bus cycle (values below 3 act as 3) |
| bus_addr | output | 27 | Host byte address driven toward the flash (bits 20:1 reach its pins) |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| dq_out | output | 16 | Write data |
| dq_oe | output | 1 | Drive enable for the data pins |
| dq_in | input | 16 | Data returned by the flash |
| rdata | output | 16 | Returned word or byte |
| rvalid | output | 1 | One-clock strobe for `rdata` |
| rindex | output | 2 | Ordinal of the read within the sequence |
| done | output | 1 | One-clock pulse at sequence end |

## Verification
The assertions check the electrical rules of a cycle on every clock:

- address and data are steady within a cycle
- write and output enable never overlap
- bit 0 of the bus address is clear
- a strobe on `rvalid` follows a read
- `done` lasts one clock
- a start during a sequence leaves the latched request untouched

Only the bench scenarios can show that each operation emits the right addresses and data in the right order. They also show the cycle count for a given length, clamping of short lengths, lane selection for odd and even byte reads, and pass-through of high address bits.

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer #(
  parameter int AW = 27,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [AW-1:0] tgt_addr,
  input  logic [15:0]   wr_data,
  input  logic [LW-1:0] cyc_len,
  output logic [AW-1:0] bus_addr,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [15:0]   dq_out,
  output logic          dq_oe,
  input  logic [15:0]   dq_in,
  output logic [15:0]   rdata,
  output logic          rvalid,
  output logic [1:0]    rindex,
  output logic          done
);
  localparam logic [2:0] OP_ID = 3'd0, OP_QRY = 3'd1, OP_PROG = 3'd2,
                         OP_RST = 3'd3, OP_BYTE = 3'd4;
  localparam logic [LW-1:0] MIN_LEN = LW'(3);

  logic          run;
  logic [2:0]    op_r, step_r;
  logic [AW-1:0] tgt_r;
  logic [15:0]   wd_r;
  logic [LW-1:0] len_r, cnt_r;
  logic [1:0]    rd_n;

  logic          s_wr, s_last;
  logic [AW-1:0] s_addr;
  logic [15:0]   s_data;

  always_comb begin
    s_wr = 1'b1; s_last = 1'b0; s_addr = '0; s_data = 16'h00F0;
    unique case (op_r)
      OP_ID: unique case (step_r)
        3'd0: begin s_addr = AW'(12'hAAA); s_data = 16'h00AA; end
        3'd1: begin s_addr = AW'(12'h554); s_data = 16'h0055; end
        3'd2: begin s_addr = AW'(12'hAAA); s_data = 16'h0090; end
        3'd3: begin s_wr = 1'b0; s_addr = AW'(0); end
        3'd4: begin s_wr = 1'b0; s_addr = AW'(2); end
        default: s_last = 1'b1;
      endcase
      OP_QRY: unique case (step_r)
        3'd0: begin s_addr = AW'(8'hAA); s_data = 16'h0098; end
        3'd1: begin s_wr = 1'b0; s_addr = AW'(8'h20); end
        3'd2: begin s_wr = 1'b0; s_addr = AW'(8'h22); end
        3'd3: begin s_wr = 1'b0; s_addr = AW'(8'h24); end
        3'd4: begin s_wr = 1'b0; s_addr = AW'(8'h4E); end
        default: s_last = 1'b1;
      endcase
      OP_PROG: unique case (step_r)
        3'd0: begin s_addr = AW'(12'hAAA); s_data = 16'h00AA; end
        3'd1: begin s_addr = AW'(12'h554); s_data = 16'h0055; end
        3'd2: begin s_addr = AW'(12'hAAA); s_data = 16'h00A0; end
        default: begin s_last = 1'b1; s_addr = {tgt_r[AW-1:1], 1'b0}; s_data = wd_r; end
      endcase
      OP_RST: s_last = 1'b1;
      default: begin s_wr = 1'b0; s_last = 1'b1; s_addr = {tgt_r[AW-1:1], 1'b0}; end
    endcase
  end

  wire cyc_end = (cnt_r == len_r - LW'(1));

  assign ce_n     = ~run;
  assign oe_n     = ~(run & ~s_wr);
  assign we_n     = ~(run & s_wr & (cnt_r != '0) & ~cyc_end);
  assign dq_oe    = run & s_wr;
  assign dq_out   = (run & s_wr) ? s_data : 16'h0000;
  assign bus_addr = run ? s_addr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; op_r <= '0; step_r <= '0; tgt_r <= '0; wd_r <= '0;
      len_r <= MIN_LEN; cnt_r <= '0; rd_n <= '0;
      done <= 1'b0; rvalid <= 1'b0; rdata <= '0; rindex <= '0;
    end else begin
      done   <= 1'b0;
      rvalid <= 1'b0;
      if (!run) begin
        if (start && op <= OP_BYTE) begin
          run <= 1'b1; op_r <= op; tgt_r <= tgt_addr; wd_r <= wr_data;
          len_r <= (cyc_len < MIN_LEN) ? MIN_LEN : cyc_len;
          step_r <= '0; cnt_r <= '0; rd_n <= '0;
        end
      end else if (cyc_end) begin
        cnt_r <= '0;
        if (!s_wr) begin
          rvalid <= 1'b1;
          rindex <= rd_n;
          rd_n   <= rd_n + 2'd1;
          if (op_r == OP_BYTE)
            rdata <= {8'h00, tgt_r[0] ? dq_in[15:8] : dq_in[7:0]};
          else
            rdata <= dq_in;
        end
        if (s_last) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          step_r <= step_r + 3'd1;
        end
      end else begin
        cnt_r <= cnt_r + LW'(1);
      end
    end
  end

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_r != '0) |-> ($stable(bus_addr) && $stable(dq_out)));
  p_we_oe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));
  p_we_in_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe && !ce_n));
  p_bit0_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !bus_addr[0]);
  p_rvalid_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(!oe_n));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start) |=> ($stable(op_r) && $stable(tgt_r) && $stable(wd_r)));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (oe_n && we_n && !dq_oe));
endmodule

// File: tb/test_nor_cmd_sequencer.sv
module test_nor_cmd_sequencer;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]  op = '0;
  logic [26:0] tgt_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  cyc_len = 8'd4;
  logic [26:0] bus_addr;
  logic        ce_n, oe_n, we_n, dq_oe, rvalid, done;
  logic [15:0] dq_out, dq_in, rdata;
  logic [1:0]  rindex;

  always #10 clk = ~clk;

  nor_cmd_sequencer i_nor_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .tgt_addr(tgt_addr),
    .wr_data(wr_data), .cyc_len(cyc_len), .bus_addr(bus_addr), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
    .rdata(rdata), .rvalid(rvalid), .rindex(rindex), .done(done));

  function automatic logic [15:0] flash_word(input logic [26:0] a);
    case (a)
      27'h0:  return 16'h00C2;
      27'h2:  return 16'h2249;
      27'h20: return 16'h0051;
      27'h22: return 16'h0052;
      27'h24: return 16'h0059;
      27'h4E: return 16'h0015;
      default: return {a[8:1] ^ 8'h3C, a[8:1]};
    endcase
  endfunction
  assign dq_in = oe_n ? 16'hZZZZ : flash_word(bus_addr);

  int errors = 0, checks = 0;
  bit logging = 1'b0;
  logic [26:0] wa [16];
  logic [15:0] wd [16];
  logic [15:0] rl [8];
  int wn = 0, rn = 0, idx_bad = 0;

  always @(posedge we_n) if (logging && wn < 16) begin
    wa[wn] = bus_addr; wd[wn] = dq_out; wn++;
  end
  always @(negedge clk) if (logging && rvalid && rn < 8) begin
    if (rindex != 2'(rn)) idx_bad++;
    rl[rn] = rdata; rn++;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int cyc, we_lo, oe_lo, ce_lo, done_lo_after;
  task automatic run_op(input logic [2:0] o, input logic [26:0] t, input logic [15:0] d,
                        input logic [7:0] len, input int inj);
    wn = 0; rn = 0; idx_bad = 0; cyc = 0; we_lo = 0; oe_lo = 0; done_lo_after = 0;
    logging = 1'b1;
    @(negedge clk);
    start = 1'b1; op = o; tgt_addr = t; wr_data = d; cyc_len = len;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (!we_n) we_lo++;
      if (!oe_n) oe_lo++;
      @(negedge clk);
      cyc++;
      start = (cyc == inj);
      if (cyc == inj) op = 3'd3;
      if (done) break;
    end
    start = 1'b0;
    @(negedge clk);
    done_lo_after = !done;
    logging = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0] op; logic [26:0] tgt; logic [15:0] wd;
    logic [3:0] steps; logic [3:0] nw; logic [3:0] nr;
    logic [26:0] lwa; logic [15:0] lwd; logic [15:0] lrd;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 27'h0,       16'h0,    4'd6, 4'd4, 4'd2, 27'h0,       16'h00F0, 16'h2249},
    '{3'd1, 27'h0,       16'h0,    4'd6, 4'd2, 4'd4, 27'h0,       16'h00F0, 16'h0015},
    '{3'd2, 27'h100000,  16'h1234, 4'd4, 4'd4, 4'd0, 27'h100000,  16'h1234, 16'h0},
    '{3'd2, 27'h4100001, 16'hBEEF, 4'd4, 4'd4, 4'd0, 27'h4100000, 16'hBEEF, 16'h0},
    '{3'd3, 27'h0,       16'h0,    4'd1, 4'd1, 4'd0, 27'h0,       16'h00F0, 16'h0},
    '{3'd4, 27'h100,     16'h0,    4'd1, 4'd0, 4'd1, 27'h0,       16'h0,    16'h0080},
    '{3'd4, 27'h101,     16'h0,    4'd1, 4'd0, 4'd1, 27'h0,       16'h0,    16'h00BC},
    '{3'd4, 27'h7FFFFFF, 16'h0,    4'd1, 4'd0, 4'd1, 27'h0,       16'h0,    16'h00C3},
    '{3'd4, 27'h1FE,     16'h0,    4'd1, 4'd0, 4'd1, 27'h0,       16'h0,    16'h00FF}
  };

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({ce_n, oe_n, we_n, dq_oe, done, rvalid}, 32'b111000, "R1 idle bus");

    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v].op, VEC[v].tgt, VEC[v].wd, 8'd4, -1);
      chk(cyc, VEC[v].steps * 4, "R11 cycle count");
      chk(done_lo_after, 1, "R11 done one clock");
      chk(wn, VEC[v].nw, "R3-R6 write count");
      chk(rn, VEC[v].nr, "R8 read count");
      chk(idx_bad, 0, "R8 rindex order");
      if (VEC[v].nw != 0) begin
        chk(wa[wn-1], VEC[v].lwa, "R5 R6 R9 last write addr");
        chk(wd[wn-1], VEC[v].lwd, "R5 R6 last write data");
      end
      if (VEC[v].nr != 0) chk(rl[rn-1], VEC[v].lrd, "R7 R8 last read data");
    end

    run_op(3'd0, 27'h0, 16'h0, 8'd4, -1);
    chk({wa[0], wd[0]}, {27'hAAA, 16'h00AA}, "R3 unlock 1");
    chk({wa[1], wd[1]}, {27'h554, 16'h0055}, "R3 unlock 2");
    chk({wa[2], wd[2]}, {27'hAAA, 16'h0090}, "R3 command");
    chk(rl[0], 16'h00C2, "R3 maker id");

    run_op(3'd1, 27'h0, 16'h0, 8'd4, -1);
    chk({wa[0], wd[0]}, {27'hAA, 16'h0098}, "R4 enter query");
    chk({rl[0], rl[1], rl[2]}, {16'h0051, 16'h0052, 16'h0059}, "R4 query reads");

    run_op(3'd2, 27'h2468, 16'h55AA, 8'd5, -1);
    chk({wa[2], wd[2]}, {27'hAAA, 16'h00A0}, "R5 program command");
    chk(cyc, 20, "R2 length 5 cycles");
    chk(we_lo, 12, "R2 we low clocks");

    run_op(3'd3, 27'h0, 16'h0, 8'd1, -1);
    chk(cyc, 3, "R2 short length clamped");
    chk(we_lo, 1, "R2 clamped we low");

    run_op(3'd4, 27'h300, 16'h0, 8'd6, -1);
    chk(oe_lo, 6, "R2 oe low whole read");
    chk(we_lo, 0, "R2 no write in read");

    run_op(3'd0, 27'h0, 16'h0, 8'd4, 5);
    chk(cyc, 24, "R10 start ignored cycles");
    chk(wn, 4, "R10 start ignored writes");
    chk(rl[1], 16'h2249, "R10 sequence intact");

    ce_lo = 0;
    @(negedge clk);
    start = 1'b1; op = 3'd6;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 12; k++) begin
      if (!ce_n || done) ce_lo++;
      @(negedge clk);
    end
    chk(ce_lo, 0, "R10 unused op code ignored");
    chk({ce_n, oe_n, we_n, dq_oe}, 4'b1110, "R1 idle after ignored op");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule